// File: doc/BRIEF.md
# Decimal Digit Subtractor with Sign-Magnitude Result

This block subtracts one BCD digit from another in a single combinational pass. The two operands are 4-bit decimal digits in the range 0 to 9. The result is a sign bit and a 4-bit BCD magnitude equal to the absolute difference. No clock or register sits on the path from inputs to outputs.

Inside, three stages run in series:

- **Complementer.** It inverts the subtrahend with plain inverters and adds binary 1010 in a small 4-bit adder. This yields the nine's complement of the subtrahend.
- **Decimal adder.** It adds that complement to the minuend. When the binary sum is greater than nine, or carries out of bit 3, it raises a decimal carry and adds 0110 to the digit.
- **Finishing stage.** It uses the decimal carry in two ways.
  - When the carry is set, the difference is positive. The stage adds the end-around carry of one.
  - When the carry is clear, the digit holds the magnitude in nine's-complement form. The stage inverts the digit and adds 1010, selected by the inverse of the carry, and discards the carry-out.

A zero difference is always reported with a positive sign.

Top module: `bcd_digit_sub`

## Requirements
- R1: The complementer output equals the bitwise inverse of the subtrahend plus binary 1010, keeping the low 4 bits, which is 9 minus the subtrahend for every valid digit.
- R2: The decimal adder raises its carry when the binary sum of the minuend and the complement exceeds 9 or carries out of bit 3, and its digit output is then the binary sum plus 0110, keeping the low 4 bits.
- R3: `diff_neg` is 1 exactly when the minuend is smaller than the subtrahend.
- R4: When the minuend is larger than the subtrahend, `diff_mag` equals minuend minus subtrahend.
- R5: When the minuend is smaller than the subtrahend, `diff_mag` equals subtrahend minus minuend, for example 5 minus 8 gives `diff_neg` = 1 and `diff_mag` = 3.
- R6: Equal operands give `diff_neg` = 0 and `diff_mag` = 0.
- R7: For valid inputs, `diff_mag` is always a valid BCD digit in the range 0 to 9.
- R8: The outputs follow the inputs without any clock edge, and settle within the same input interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| minuend | input | 4 | BCD digit the subtrahend is taken from |
| subtrahend | input | 4 | BCD digit taken away |
| diff_neg | output | 1 | 1 when the difference is negative |
| diff_mag | output | 4 | BCD magnitude of the difference |

## Verification
On every input change, the bound checker tests several properties for valid inputs:

- the complementer output against 9 minus the subtrahend;
- the decimal adder's carry and corrected digit against the arithmetic sum;
- the magnitude range;
- the equal-operand case.

Each check compares signals driven by separate stages. The sign and magnitude for every ordering of operands, and the fact that results appear without a clock edge, are shown by the bench. The bench sweeps all hundred digit pairs and compares each result with the absolute difference it computes itself.

// File: rtl/bcd_sub_pkg.sv
package bcd_sub_pkg;

    localparam int DIGIT_W   = 4;
    localparam int DIGIT_MAX = 9;

    typedef logic [DIGIT_W-1:0] digit_t;

    // carry and corrected digit leaving the decimal adder
    typedef struct packed {
        logic   dcarry;
        digit_t digit;
    } dec_sum_t;

    // sign-magnitude result
    typedef struct packed {
        logic   neg;
        digit_t mag;
    } sm_result_t;

    localparam digit_t K_TEN = digit_t'(4'b1010);
    localparam digit_t K_SIX = digit_t'(4'b0110);

    // plain 4-bit add with carry in, carry out dropped
    function automatic digit_t add4(input digit_t x, input digit_t y, input logic cin);
        logic [DIGIT_W:0] t;
        t = {1'b0, x} + {1'b0, y} + {{DIGIT_W{1'b0}}, cin};
        return t[DIGIT_W-1:0];
    endfunction

endpackage

// File: rtl/nines_comp.sv
module nines_comp
    import bcd_sub_pkg::*;
(
    input  digit_t d_in,
    output digit_t d_nc
);
    digit_t inv;

    always_comb begin
        for (int i = 0; i < DIGIT_W; i++) begin
            inv[i] = ~d_in[i];
        end
    end

    assign d_nc = add4(inv, K_TEN, 1'b0);
endmodule

// File: rtl/dec_adder.sv
module dec_adder
    import bcd_sub_pkg::*;
(
    input  digit_t   op_x,
    input  digit_t   op_y,
    output dec_sum_t sum_o
);
    logic [DIGIT_W:0] raw;
    logic             over;

    always_comb begin
        raw  = {1'b0, op_x} + {1'b0, op_y};
        over = raw[DIGIT_W] | (raw[3] & (raw[2] | raw[1]));
        sum_o.dcarry = over;
        sum_o.digit  = add4(raw[DIGIT_W-1:0], over ? K_SIX : '0, 1'b0);
    end
endmodule

// File: rtl/sm_finish.sv
module sm_finish
    import bcd_sub_pkg::*;
(
    input  dec_sum_t   sum_i,
    output sm_result_t res_o
);
    digit_t flip;
    digit_t addend;
    logic   neg_raw;

    always_comb begin
        neg_raw = ~sum_i.dcarry;
        flip    = sum_i.digit ^ {DIGIT_W{neg_raw}};
        // negative: add 1010; positive: add end-around carry 0001
        addend  = {neg_raw, 1'b0, neg_raw, sum_i.dcarry};
        res_o.mag = add4(flip, addend, 1'b0);
        // no negative zero
        res_o.neg = neg_raw & (res_o.mag != '0);
    end
endmodule

// File: rtl/bcd_digit_sub.sv
module bcd_digit_sub
    import bcd_sub_pkg::*;
(
    input  logic [3:0] minuend,
    input  logic [3:0] subtrahend,
    output logic       diff_neg,
    output logic [3:0] diff_mag
);
    digit_t     w_ncomp;
    dec_sum_t   w_dsum;
    sm_result_t w_res;

    nines_comp u_nc (
        .d_in (subtrahend),
        .d_nc (w_ncomp)
    );

    dec_adder u_add (
        .op_x  (minuend),
        .op_y  (w_ncomp),
        .sum_o (w_dsum)
    );

    sm_finish u_fin (
        .sum_i (w_dsum),
        .res_o (w_res)
    );

    assign diff_neg = w_res.neg;
    assign diff_mag = w_res.mag;
endmodule

// File: rtl/bcd_digit_sub_chk.sv
module bcd_digit_sub_chk
    import bcd_sub_pkg::*;
(
    input logic [3:0] minuend,
    input logic [3:0] subtrahend,
    input logic       diff_neg,
    input logic [3:0] diff_mag,
    input digit_t     ncomp,
    input dec_sum_t   dsum
);
    logic       ok_in;
    logic [4:0] ref_sum;

    always_comb begin
        ok_in   = (minuend <= 4'd9) && (subtrahend <= 4'd9);
        ref_sum = {1'b0, minuend} + (5'd9 - {1'b0, subtrahend});
        if (ok_in) begin
            p_ninecomp_r1: assert ({1'b0, ncomp} + {1'b0, subtrahend} == 5'd9);
            p_dcarry_r2: assert (dsum.dcarry == (ref_sum > 5'd9));
            if (dsum.dcarry)
                p_dcorrect_r2: assert ({1'b0, dsum.digit} == ref_sum - 5'd10);
            p_mag_range_r7: assert (diff_mag <= 4'd9);
            if (minuend == subtrahend)
                p_equal_zero_r6: assert (!diff_neg && diff_mag == 4'd0);
            p_sign_r3: assert (diff_neg == (minuend < subtrahend));
        end
    end
endmodule

bind bcd_digit_sub bcd_digit_sub_chk u_chk (
    .minuend    (minuend),
    .subtrahend (subtrahend),
    .diff_neg   (diff_neg),
    .diff_mag   (diff_mag),
    .ncomp      (w_ncomp),
    .dsum       (w_dsum)
);

// File: tb/bcd_digit_sub_bench.sv
module bcd_digit_sub_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] minuend = 4'd0;
    logic [3:0] subtrahend = 4'd0;
    logic       diff_neg;
    logic [3:0] diff_mag;
    int         n_tests = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    bcd_digit_sub u_bcd_digit_sub (
        .minuend    (minuend),
        .subtrahend (subtrahend),
        .diff_neg   (diff_neg),
        .diff_mag   (diff_mag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d",
                     req, minuend, subtrahend, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R6: starting inputs 0,0 give +0
        @(negedge clk);
        chk("R6 initial sign", int'(diff_neg), 0);
        chk("R6 initial mag", int'(diff_mag), 0);
        for (int a = 0; a <= 9; a++) begin
            for (int b = 0; b <= 9; b++) begin
                @(posedge clk);
                minuend    = 4'(a);
                subtrahend = 4'(b);
                // R8: sampled half a period later, no clock edge in between
                @(negedge clk);
                chk("R3 sign", int'(diff_neg), (a < b) ? 1 : 0);
                chk("R7 range", int'(diff_mag <= 4'd9), 1);
                if (a > b) begin
                    chk("R4 mag", int'(diff_mag), a - b);
                    chk("R2 carry path positive", int'(diff_neg), 0);
                end else if (a < b) begin
                    chk("R5 mag", int'(diff_mag), b - a);
                end else begin
                    chk("R6 mag", int'(diff_mag), 0);
                    chk("R6 sign", int'(diff_neg), 0);
                end
                if (a == 9) chk("R1 complement", int'(diff_mag), 9 - b);
            end
        end
        // R5: named example 5 - 8
        @(posedge clk);
        minuend = 4'd5; subtrahend = 4'd8;
        #1;
        chk("R8 same-interval sign", int'(diff_neg), 1);
        chk("R5 example mag", int'(diff_mag), 3);
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule